// File: doc/BRIEF.md
# Serial Port Register Front End with Delayed Interrupts

This block is the byte-wide register front end of a classic PC-style serial port. A CPU reaches it through a small bus made of an address, read and write strobes, write data and combinational read data. On the other side it talks to a byte console. The console offers a receive-available flag with its byte and accepts a receive pop. The block in turn offers a transmit push with its byte. No bit shifting, baud generation or FIFO is modelled. The divisor bytes are stored and read back but drive nothing.

Interrupts are not raised at once. Two conditions can schedule an interrupt. One is a transmit-empty enable taking effect. The other is received data being available while its enable is set. Each such event loads a per-source countdown of `DELAY_CYC` clock cycles. When the countdown expires, the interrupt line rises and the source's status bit is set, but only if that source's enable is still set. The transmitter always reports itself empty, so software that enables the transmit interrupt sees it after the delay.

Register offsets within the 8-byte window are: 0 data or divisor low, 1 interrupt enable or divisor high, 2 interrupt identity on read and FIFO control on write, 3 line control, 4 modem control, 5 line status, 6 modem status, and 7 scratch.

Top module: `uart_regif`

## Requirements
- R1: After reset, `irq` is 0. Line control, interrupt enable, modem control and both divisor bytes read 0. The identity register reads 0x01, and no interrupt fires afterwards without a new schedule.
- R2: When bit 7 of line control is 1, offsets 0 and 1 read and write the divisor low and high bytes. These writes neither push to the console nor change the interrupt enable register. When bit 7 is 0, offset 0 is data and offset 1 is the interrupt enable register (bit 0 receive enable, bit 1 transmit enable, bits 7:4 read 0).
- R3: A data read returns the console byte and pops it when one is available. With the console empty, it returns 0 and does not pop. Either way it drops `irq` and clears the receive status on the same clock edge.
- R4: A data write presents the byte on `con_tx_data` with `con_tx_push` high in the same cycle. On that edge it drops `irq` and clears the transmit status.
- R5: With the transmit enable set, `irq` rises exactly `DELAY_CYC` cycles after the edge of either trigger. One trigger is an interrupt enable write that sets bit 1. The other is a data write. The identity register then reads 0x02.
- R6: An interrupt enable write with bit 0 set while console data is available raises `irq` exactly `DELAY_CYC` cycles later. While the receive status is set, the identity register reads 0x04, ahead of any pending transmit source.
- R7: After a data read that popped a byte, the receive interrupt is scheduled again if the console still has data on the next cycle and bit 0 is set. `irq` then rises `DELAY_CYC + 1` cycles after the read edge. If the console is empty, nothing is scheduled.
- R8: An interrupt enable write with a source's enable bit clear cancels that source's countdown. If either bit is clear, it also drops `irq` on that edge. A cancelled source never fires later.
- R9: A new schedule of a source that is already counting restarts its delay from the full `DELAY_CYC`.
- R10: Reading the identity register while transmit is the reported source returns 0x02 and clears the transmit status, so the next read returns 0x01.
- R11: Line status reads 0x60 with bit 0 equal to console data available. Bits 5 and 6 are always 1. Modem status reads the constant `MSR_VALUE`.
- R12: Line control reads back all 8 bits written. Modem control reads back the low 5 bits written. Scratch reads 0 and ignores writes. Writes to offset 2 leave the identity register unchanged.
- R13: An access with an address of 8 or more raises `bus_err` in that cycle, returns 0, and has no effect on registers or the console.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| bus_err | output | 1 | Access outside offsets 0 to 7 |
| con_rx_valid | input | 1 | Console has a receive byte |
| con_rx_data | input | 8 | Current console receive byte |
| con_rx_pop | output | 1 | Consume the current receive byte |
| con_tx_push | output | 1 | Transmit byte is valid |
| con_tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request, registered |

## Verification
Read data, `bus_err`, `con_rx_pop` and `con_tx_push` are combinational in the cycle of the strobe. The bench samples them one time unit after driving that cycle's inputs. Every effect on `irq` is registered. A dropping access shows on the next falling edge. A delayed rise appears `DELAY_CYC` edges after the triggering edge, or `DELAY_CYC + 1` edges for the rearm after a pop. The bench therefore checks `irq` low one falling edge before the due edge and high on the due edge, which pins the delay to the exact cycle.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFF_W  = 3;
  localparam int unsigned SRC_N  = 2;   // interrupt sources: 0 receive, 1 transmit

  typedef enum logic [OFF_W-1:0] {
    OFF_DATA = 3'd0,
    OFF_IEN  = 3'd1,
    OFF_IDN  = 3'd2,
    OFF_LCTL = 3'd3,
    OFF_MCTL = 3'd4,
    OFF_LSTS = 3'd5,
    OFF_MSTS = 3'd6,
    OFF_SCR  = 3'd7
  } reg_off_e;

  localparam int unsigned SRC_RX   = 0;  // also the enable bit position
  localparam int unsigned SRC_TX   = 1;
  localparam int unsigned BANK_BIT = 7;  // line control bit switching offsets 0/1
  localparam int unsigned IEN_KEEP = 4;  // stored enable bits
  localparam int unsigned MCTL_KEEP = 5; // stored modem control bits

  localparam logic [BYTE_W-1:0] IDN_NONE = 8'h01;
  localparam logic [BYTE_W-1:0] IDN_TX   = 8'h02;
  localparam logic [BYTE_W-1:0] IDN_RX   = 8'h04;
  localparam logic [BYTE_W-1:0] LSTS_IDLE = 8'h60; // holding empty + shifter empty

endpackage

// File: rtl/uart_irq_delay.sv
module uart_irq_delay #(
  parameter int unsigned DELAY_CYC = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sched_i,
  input  logic cancel_i,
  output logic fire_o
);
  localparam int unsigned CNT_W = $clog2(DELAY_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (sched_i)
      cnt_d = CNT_W'(DELAY_CYC);
    else if (cancel_i)
      cnt_d = '0;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  assign cnt_en = sched_i | cancel_i | (cnt_q != '0);
  assign fire_o = (cnt_q == CNT_W'(1)) & ~sched_i & ~cancel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lctl_o,
  output logic [BYTE_W-1:0] ien_o,
  output logic [BYTE_W-1:0] mctl_o,
  output logic [BYTE_W-1:0] div_lo_o,
  output logic [BYTE_W-1:0] div_hi_o,
  output logic              ien_wr_o
);
  logic [BYTE_W-1:0]    lctl_q, div_lo_q, div_hi_q;
  logic [IEN_KEEP-1:0]  ien_q;
  logic [MCTL_KEEP-1:0] mctl_q;
  logic bank;
  logic lctl_en, ien_en, mctl_en, dlo_en, dhi_en;

  assign bank    = lctl_q[BANK_BIT];
  assign lctl_en = wr_i && (off_i == OFF_LCTL);
  assign mctl_en = wr_i && (off_i == OFF_MCTL);
  assign ien_en  = wr_i && (off_i == OFF_IEN)  && !bank;
  assign dlo_en  = wr_i && (off_i == OFF_DATA) &&  bank;
  assign dhi_en  = wr_i && (off_i == OFF_IEN)  &&  bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lctl_q   <= '0;
      ien_q    <= '0;
      mctl_q   <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else begin
      if (lctl_en) lctl_q   <= wdata_i;
      if (ien_en)  ien_q    <= wdata_i[IEN_KEEP-1:0];
      if (mctl_en) mctl_q   <= wdata_i[MCTL_KEEP-1:0];
      if (dlo_en)  div_lo_q <= wdata_i;
      if (dhi_en)  div_hi_q <= wdata_i;
    end
  end

  assign lctl_o   = lctl_q;
  assign ien_o    = {{(BYTE_W-IEN_KEEP){1'b0}}, ien_q};
  assign mctl_o   = {{(BYTE_W-MCTL_KEEP){1'b0}}, mctl_q};
  assign div_lo_o = div_lo_q;
  assign div_hi_o = div_hi_q;
  assign ien_wr_o = ien_en;

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DELAY_CYC = 45,
  parameter logic [7:0]  MSR_VALUE = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_err,
  input  logic              con_rx_valid,
  input  logic [7:0]        con_rx_data,
  output logic              con_rx_pop,
  output logic              con_tx_push,
  output logic [7:0]        con_tx_data,
  output logic              irq
);
  logic              in_range, rd_ok, wr_ok, bank;
  logic [OFF_W-1:0]  off;
  logic [BYTE_W-1:0] lctl, ien, mctl, div_lo, div_hi, idn_val, rd_mux;
  logic              ien_wr, data_rd, data_wr, idn_rd;
  logic [SRC_N-1:0]  sched, cancel, fire;
  logic [SRC_N-1:0]  st_q, st_d, st_clr;
  logic              irq_q, irq_d, irq_set, irq_clr;
  logic              recheck_q, rearm;

  assign in_range = (bus_addr >> OFF_W) == '0;
  assign off      = bus_addr[OFF_W-1:0];
  assign rd_ok    = bus_rd && in_range;
  assign wr_ok    = bus_wr && in_range;
  assign bus_err  = (bus_rd || bus_wr) && !in_range;

  uart_bank_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_ok),
    .off_i    (off),
    .wdata_i  (bus_wdata),
    .lctl_o   (lctl),
    .ien_o    (ien),
    .mctl_o   (mctl),
    .div_lo_o (div_lo),
    .div_hi_o (div_hi),
    .ien_wr_o (ien_wr)
  );

  assign bank    = lctl[BANK_BIT];
  assign data_rd = rd_ok && (off == OFF_DATA) && !bank;
  assign data_wr = wr_ok && (off == OFF_DATA) && !bank;
  assign idn_rd  = rd_ok && (off == OFF_IDN);

  assign con_rx_pop  = data_rd && con_rx_valid;
  assign con_tx_push = data_wr;
  assign con_tx_data = bus_wdata;

  // one-cycle look at the console after a pop
  assign rearm = recheck_q && con_rx_valid && ien[SRC_RX];

  always_comb begin
    sched[SRC_RX]  = (ien_wr && bus_wdata[SRC_RX] && con_rx_valid) || rearm;
    cancel[SRC_RX] = ien_wr && !bus_wdata[SRC_RX];
    sched[SRC_TX]  = (ien_wr && bus_wdata[SRC_TX]) || (data_wr && ien[SRC_TX]);
    cancel[SRC_TX] = ien_wr && !bus_wdata[SRC_TX];
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    uart_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .sched_i  (sched[g]),
      .cancel_i (cancel[g]),
      .fire_o   (fire[g])
    );
  end

  // status and interrupt line next state
  always_comb begin
    st_clr[SRC_RX] = data_rd;
    st_clr[SRC_TX] = data_wr || (idn_rd && !st_q[SRC_RX] && st_q[SRC_TX]);
    st_d    = (st_q & ~st_clr) | (fire & ien[SRC_N-1:0]);
    irq_set = |(fire & ien[SRC_N-1:0]);
    irq_clr = data_rd || data_wr ||
              (ien_wr && !(bus_wdata[SRC_RX] && bus_wdata[SRC_TX]));
    irq_d   = (irq_q && !irq_clr) || irq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      irq_q     <= 1'b0;
      recheck_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      irq_q     <= irq_d;
      recheck_q <= con_rx_pop;
    end
  end

  assign irq = irq_q;

  always_comb begin
    if (st_q[SRC_RX])      idn_val = IDN_RX;
    else if (st_q[SRC_TX]) idn_val = IDN_TX;
    else                   idn_val = IDN_NONE;
  end

  always_comb begin
    unique case (off)
      OFF_DATA: rd_mux = bank ? div_lo : (con_rx_valid ? con_rx_data : '0);
      OFF_IEN:  rd_mux = bank ? div_hi : ien;
      OFF_IDN:  rd_mux = idn_val;
      OFF_LCTL: rd_mux = lctl;
      OFF_MCTL: rd_mux = mctl;
      OFF_LSTS: rd_mux = LSTS_IDLE | {7'b0, con_rx_valid};
      OFF_MSTS: rd_mux = MSR_VALUE;
      default:  rd_mux = '0;
    endcase
  end

  assign bus_rdata = rd_ok ? rd_mux : '0;

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              bus_err,
  input logic              con_rx_valid,
  input logic              con_rx_pop,
  input logic              con_tx_push,
  input logic              irq,
  input logic              bank,
  input logic [1:0]        st
);
  // R3
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    con_rx_pop |-> con_rx_valid);

  // R4
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(con_tx_push && con_rx_pop));

  // R13
  err_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!con_tx_push && !con_rx_pop && bus_rdata == 8'h00));

  // R5
  irq_rise_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (st != 2'b00));

  // R8
  disable_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1) && !bank && bus_wdata[1:0] == 2'b00) |=> !irq);

  // R11
  lsts_empty_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(5)) |-> (bus_rdata[6:5] == 2'b11 && bus_rdata[0] == con_rx_valid));

endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .bus_err      (bus_err),
  .con_rx_valid (con_rx_valid),
  .con_rx_pop   (con_rx_pop),
  .con_tx_push  (con_tx_push),
  .irq          (irq),
  .bank         (bank),
  .st           (st_q)
);

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 20;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          bus_err, con_rx_valid, con_rx_pop, con_tx_push, irq;
  logic [7:0]    con_rx_data, con_tx_data;

  // console model
  logic [7:0] rxq [8];
  logic [3:0] rx_tail = '0;
  logic [3:0] rx_head = '0;
  int         pops = 0;
  int         tx_cnt = 0;
  logic [7:0] last_tx = '0;

  assign con_rx_valid = (rx_tail != rx_head);
  assign con_rx_data  = rxq[rx_head[2:0]];

  always @(posedge clk) begin
    if (con_rx_pop) begin
      rx_head <= rx_head + 4'd1;
      pops    <= pops + 1;
    end
    if (con_tx_push) begin
      last_tx <= con_tx_data;
      tx_cnt  <= tx_cnt + 1;
    end
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif #(.ADDR_W(AW), .DELAY_CYC(DLY), .MSR_VALUE(8'hB0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .con_rx_valid(con_rx_valid), .con_rx_data(con_rx_data), .con_rx_pop(con_rx_pop),
    .con_tx_push(con_tx_push), .con_tx_data(con_tx_data), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_rx(input logic [7:0] b);
    rxq[rx_tail[2:0]] = b;
    rx_tail = rx_tail + 4'd1;
  endtask

  typedef struct packed {
    logic       w;
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] e;
    logic [3:0] r;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'h3, 8'h1B, 8'h00, 4'd12},  // R12 line control write
    '{1'b0, 4'h3, 8'h00, 8'h1B, 4'd12},
    '{1'b1, 4'h4, 8'hFF, 8'h00, 4'd12},  // R12 modem control keeps 5 bits
    '{1'b0, 4'h4, 8'h00, 8'h1F, 4'd12},
    '{1'b1, 4'h7, 8'hA5, 8'h00, 4'd12},  // R12 scratch ignored
    '{1'b0, 4'h7, 8'h00, 8'h00, 4'd12},
    '{1'b0, 4'h5, 8'h00, 8'h60, 4'd11},  // R11 line status, no data
    '{1'b0, 4'h6, 8'h00, 8'hB0, 4'd11},  // R11 modem status
    '{1'b1, 4'h2, 8'hC7, 8'h00, 4'd12},  // R12 FIFO control ignored
    '{1'b0, 4'h2, 8'h00, 8'h01, 4'd12},
    '{1'b1, 4'h3, 8'h83, 8'h00, 4'd2},   // R2 switch to divisor bank
    '{1'b1, 4'h0, 8'h34, 8'h00, 4'd2},
    '{1'b1, 4'h1, 8'h12, 8'h00, 4'd2},
    '{1'b0, 4'h0, 8'h00, 8'h34, 4'd2},
    '{1'b0, 4'h1, 8'h00, 8'h12, 4'd2},
    '{1'b1, 4'h3, 8'h03, 8'h00, 4'd2},   // R2 back to data bank
    '{1'b0, 4'h1, 8'h00, 8'h00, 4'd2}    // R2 enable register untouched
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", irq, 1'b0);
    rd(4'h2, v); check("R1 identity", v, 8'h01);
    rd(4'h3, v); check("R1 line control", v, 8'h00);
    rd(4'h1, v); check("R1 enable", v, 8'h00);
    rd(4'h4, v); check("R1 modem control", v, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].w) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, v);
        check($sformatf("R%0d table[%0d]", VEC[i].r, i), v, VEC[i].e);
      end
    end
    check("R2 divisor writes not pushed", tx_cnt, 0);

    // R4 data write with interrupts disabled
    wr(4'h0, 8'h41);
    check("R4 push count", tx_cnt, 1);
    check("R4 push byte", last_tx, 8'h41);
    wait_cyc(DLY + 2);
    check("R4 no irq when disabled", irq, 1'b0);

    // R5 transmit enable schedules
    wr(4'h1, 8'h02);
    wait_cyc(DLY - 1); check("R5 irq before delay", irq, 1'b0);
    wait_cyc(1);       check("R5 irq at delay", irq, 1'b1);
    rd(4'h2, v); check("R5 identity tx", v, 8'h02);
    rd(4'h2, v); check("R10 identity after clear", v, 8'h01);
    wr(4'h0, 8'h42);
    check("R4 irq dropped by write", irq, 1'b0);
    check("R4 push byte 2", last_tx, 8'h42);
    wait_cyc(DLY - 1); check("R5 data write before delay", irq, 1'b0);
    wait_cyc(1);       check("R5 data write at delay", irq, 1'b1);

    // R8 disable drops and cancels
    wr(4'h1, 8'h00);
    check("R8 irq dropped", irq, 1'b0);
    wr(4'h1, 8'h02);
    wait_cyc(5);
    wr(4'h1, 8'h00);
    wait_cyc(DLY + 5);
    check("R8 cancelled never fires", irq, 1'b0);

    // R9 retrigger restarts the delay
    wr(4'h1, 8'h02);
    wait_cyc(10);
    wr(4'h1, 8'h02);
    wait_cyc(DLY - 1); check("R9 restarted not yet", irq, 1'b0);
    wait_cyc(1);       check("R9 restarted fires", irq, 1'b1);
    wr(4'h1, 8'h00);

    // R6 / R7 receive path
    load_rx(8'hA1);
    load_rx(8'hB2);
    rd(4'h5, v); check("R11 line status data ready", v, 8'h61);
    wr(4'h1, 8'h03);
    wait_cyc(DLY - 1); check("R6 irq before delay", irq, 1'b0);
    wait_cyc(1);       check("R6 irq at delay", irq, 1'b1);
    rd(4'h2, v); check("R6 identity rx priority", v, 8'h04);
    rd(4'h0, v); check("R3 read byte 1", v, 8'hA1);
    check("R3 irq dropped by read", irq, 1'b0);
    check("R3 pop count", pops, 1);
    wait_cyc(DLY);     check("R7 rearm not yet", irq, 1'b0);
    wait_cyc(1);       check("R7 rearm fires", irq, 1'b1);
    rd(4'h2, v); check("R7 identity rx", v, 8'h04);
    rd(4'h0, v); check("R3 read byte 2", v, 8'hB2);
    wait_cyc(DLY + 3);
    check("R7 no rearm when empty", irq, 1'b0);
    rd(4'h2, v); check("R3 rx status cleared", v, 8'h02);
    rd(4'h0, v); check("R3 empty read value", v, 8'h00);
    check("R3 empty read no pop", pops, 2);
    wr(4'h1, 8'h00);

    // R13 out-of-range access
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'hB; bus_wdata = 8'h55;
    #1 check("R13 err on write", bus_err, 1'b1);
    check("R13 no push", con_tx_push, 1'b0);
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 4'h9;
    #1 check("R13 err on read", bus_err, 1'b1);
    check("R13 read zero", bus_rdata, 8'h00);
    @(negedge clk);
    bus_rd = 1'b0;
    rd(4'h3, v); check("R13 line control unchanged", v, 8'h03);
    check("R13 push count unchanged", tx_cnt, 2);

    // R1 reset mid-operation
    wr(4'h3, 8'h9B);
    wr(4'h1, 8'h02);
    @(negedge clk) rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    check("R1 irq after reset", irq, 1'b0);
    rd(4'h3, v); check("R1 line control cleared", v, 8'h00);
    rd(4'h1, v); check("R1 enable cleared", v, 8'h00);
    wr(4'h3, 8'h80);
    rd(4'h0, v); check("R1 divisor low cleared", v, 8'h00);
    rd(4'h1, v); check("R1 divisor high cleared", v, 8'h00);
    wr(4'h3, 8'h00);
    wait_cyc(DLY + 2);
    check("R1 no stale fire", irq, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule